// File: doc/BRIEF.md
# Hypercube Dimension-Order Router Node

This block is the switching node that sits at one vertex of a binary hypercube network of dimension DIM. The network has 2^DIM vertices, each with a distinct DIM-bit label fixed at elaboration through the `NODE_ADDR` parameter. Two vertices are joined by a bidirectional link exactly when their labels differ in one bit, so every node has one link pair per dimension plus a local port. The local port injects messages from the attached processor and ejects messages addressed to it.

Every message is a single flit. The flit carries its destination label in its top DIM bits and the payload below them. When a flit arrives on any input, the node XORs the destination with its own label. If the result is zero, the flit is ejected locally. Otherwise it leaves on the link of the lowest set bit of that difference. Each hop clears one differing bit, so a message travels exactly as many hops as the Hamming distance between source and destination. For example, in a 3-cube a message from 011 to 110 goes out on dimension 0, reaches 010, then goes out on dimension 2.

Each output has a one-flit register and a round-robin arbiter. All ports use valid/ready handshakes. A flit waits at its input, with ready low, until it wins the arbiter of its output.

Top module: `hcube_router`

## Requirements
- R1: A flit whose destination field (flit bits [FLIT_W-1 -: DIM]) equals `NODE_ADDR` leaves only on the eject port, with its payload (flit bits [PAYLOAD_W-1:0]) unchanged.
- R2: A flit whose destination differs from `NODE_ADDR` leaves on the link whose index is the lowest bit position where the two labels differ. Link index d connects to the neighbour whose label differs in bit d.
- R3: In a network of 2^DIM nodes where no output is stalled, a flit accepted at a source's inject port appears on the destination's eject port exactly H clock edges later, where H is the Hamming distance. No other node ejects it.
- R4: Each node adds one register stage: a flit accepted at an edge is on the chosen output from that edge onward.
- R5: An output register accepts a new flit only when it is empty. A full output keeps valid high and its flit stable until ready is seen high at a clock edge, and it becomes empty at that edge.
- R6: Input ports are numbered with links 0..DIM-1 first and the inject port as DIM. Each output's arbiter has a pointer that resets to 0. The arbiter grants the first requester found scanning upward from the pointer, wrapping around, then moves the pointer to one above the winner.
- R7: After reset all link and eject valid outputs are low.
- R8: Each output grants at most one input per cycle. A losing input sees ready low and keeps its flit waiting at its port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_valid | input | 1 | Local inject flit valid |
| inj_ready | output | 1 | Local inject flit accepted |
| inj_flit | input | FLIT_W | Local inject flit {dest, payload} |
| ej_valid | output | 1 | Eject flit valid |
| ej_ready | input | 1 | Eject sink ready |
| ej_flit | output | FLIT_W | Ejected flit |
| lk_in_valid | input | DIM | Per-dimension incoming flit valid |
| lk_in_ready | output | DIM | Per-dimension incoming flit accepted |
| lk_in_flit | input | DIM*FLIT_W | Incoming flits, dimension d at slice d |
| lk_out_valid | output | DIM | Per-dimension outgoing flit valid |
| lk_out_ready | input | DIM | Per-dimension neighbour ready |
| lk_out_flit | output | DIM*FLIT_W | Outgoing flits, dimension d at slice d |

## Verification
A flit is on its first-hop link at the first falling edge after the inject handshake edge. It reaches the destination eject port H rising edges after that handshake. The bench counts rising edges from the handshake and samples every output on falling edges, so it compares the count against the Hamming distance it computed for all 64 source/destination pairs. In the contention case, each ejected flit is visible for exactly one falling edge while ready is high. The bench records the flits in that order and compares against the order it derives from the pointer rule.

// File: rtl/hc_pkg.sv
package hc_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;
endpackage

// File: rtl/hc_route_sel.sv
module hc_route_sel #(
    parameter int DIM = 3,
    parameter logic [DIM-1:0] NODE_ADDR = '0
) (
    input  logic [DIM-1:0] dest,
    output logic [DIM:0]   port_oh
);
    logic [DIM-1:0] diff;
    logic           found;

    always_comb begin
        diff    = dest ^ NODE_ADDR;
        port_oh = '0;
        found   = 1'b0;
        for (int d = 0; d < DIM; d++) begin
            if (!found && diff[d]) begin
                port_oh[d] = 1'b1;
                found      = 1'b1;
            end
        end
        if (!found) begin
            port_oh[DIM] = 1'b1;
        end
    end
endmodule

// File: rtl/hc_rr_arb.sv
module hc_rr_arb #(
    parameter int N = 4,
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } arb_state_t;

    arb_state_t state_d, state_q;
    int         idx;
    logic       hit;

    always_comb begin
        state_d = state_q;
        grant   = '0;
        hit     = 1'b0;
        idx     = 0;
        if (en) begin
            for (int k = 0; k < N; k++) begin
                idx = (int'(state_q.ptr) + k) % N;
                if (!hit && req[idx]) begin
                    grant[idx]    = 1'b1;
                    hit           = 1'b1;
                    state_d.ptr   = PTR_W'((idx + 1) % N);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_grant_has_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
endmodule

// File: rtl/hc_out_slot.sv
module hc_out_slot #(
    parameter int W = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic         empty,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    import hc_pkg::*;

    typedef struct packed {
        slot_e        st;
        logic [W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (load) begin
            slot_d.st   = SLOT_FULL;
            slot_d.data = load_data;
        end else if (slot_q.st == SLOT_FULL && out_ready) begin
            slot_d.st = SLOT_EMPTY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '{st: SLOT_EMPTY, data: '0};
        end else begin
            slot_q <= slot_d;
        end
    end

    assign empty     = (slot_q.st == SLOT_EMPTY);
    assign out_valid = (slot_q.st == SLOT_FULL);
    assign out_data  = slot_q.data;

    assert_hold_when_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_load_only_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !out_valid);
endmodule

// File: rtl/hcube_router.sv
module hcube_router #(
    parameter int DIM = 3,
    parameter int PAYLOAD_W = 32,
    parameter logic [DIM-1:0] NODE_ADDR = '0,
    localparam int FLIT_W = DIM + PAYLOAD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inj_valid,
    output logic                  inj_ready,
    input  logic [FLIT_W-1:0]     inj_flit,
    output logic                  ej_valid,
    input  logic                  ej_ready,
    output logic [FLIT_W-1:0]     ej_flit,
    input  logic [DIM-1:0]        lk_in_valid,
    output logic [DIM-1:0]        lk_in_ready,
    input  logic [DIM*FLIT_W-1:0] lk_in_flit,
    output logic [DIM-1:0]        lk_out_valid,
    input  logic [DIM-1:0]        lk_out_ready,
    output logic [DIM*FLIT_W-1:0] lk_out_flit
);
    localparam int P = DIM + 1;

    logic [P-1:0]             in_v;
    logic [P-1:0]             in_r;
    logic [P-1:0][FLIT_W-1:0] in_f;
    logic [P-1:0][P-1:0]      route_oh;
    logic [P-1:0][P-1:0]      gr_all;
    logic [P-1:0]             slot_v;
    logic [P-1:0]             slot_r;
    logic [P-1:0][FLIT_W-1:0] slot_f;

    assign in_v[DIM]   = inj_valid;
    assign in_f[DIM]   = inj_flit;
    assign inj_ready   = in_r[DIM];
    assign lk_in_ready = in_r[DIM-1:0];

    assign ej_valid    = slot_v[DIM];
    assign ej_flit     = slot_f[DIM];
    assign slot_r[DIM] = ej_ready;

    for (genvar d = 0; d < DIM; d++) begin : g_link
        assign in_v[d]   = lk_in_valid[d];
        assign in_f[d]   = lk_in_flit[d*FLIT_W +: FLIT_W];
        assign lk_out_valid[d] = slot_v[d];
        assign lk_out_flit[d*FLIT_W +: FLIT_W] = slot_f[d];
        assign slot_r[d] = lk_out_ready[d];
    end

    for (genvar i = 0; i < P; i++) begin : g_in
        hc_route_sel #(
            .DIM       (DIM),
            .NODE_ADDR (NODE_ADDR)
        ) u_route (
            .dest    (in_f[i][FLIT_W-1 -: DIM]),
            .port_oh (route_oh[i])
        );

        assert_local_dest_ejects_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_v[i] && in_r[i] && in_f[i][FLIT_W-1 -: DIM] == NODE_ADDR) |=> ej_valid);

        assert_remote_dest_forwards_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_v[i] && in_r[i] && in_f[i][FLIT_W-1 -: DIM] != NODE_ADDR) |=> (lk_out_valid != '0));
    end

    for (genvar d = 0; d < DIM; d++) begin : g_hopchk
        assert_arrival_bit_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_in_valid[d] && lk_in_ready[d]) |-> (lk_in_flit[d*FLIT_W + PAYLOAD_W + d] == NODE_ADDR[d]));
    end

    always_comb begin
        for (int i = 0; i < P; i++) begin
            in_r[i] = 1'b0;
            for (int o = 0; o < P; o++) begin
                in_r[i] = in_r[i] | gr_all[o][i];
            end
        end
    end

    for (genvar o = 0; o < P; o++) begin : g_out
        logic [P-1:0]      col_req;
        logic [FLIT_W-1:0] mux_f;
        logic              empty;

        always_comb begin
            for (int i = 0; i < P; i++) begin
                col_req[i] = in_v[i] & route_oh[i][o];
            end
        end

        hc_rr_arb #(
            .N (P)
        ) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (empty),
            .req   (col_req),
            .grant (gr_all[o])
        );

        always_comb begin
            mux_f = '0;
            for (int i = 0; i < P; i++) begin
                if (gr_all[o][i]) begin
                    mux_f = in_f[i];
                end
            end
        end

        hc_out_slot #(
            .W (FLIT_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (|gr_all[o]),
            .load_data (mux_f),
            .empty     (empty),
            .out_valid (slot_v[o]),
            .out_ready (slot_r[o]),
            .out_data  (slot_f[o])
        );
    end
endmodule

// File: tb/hcube_router_bench.sv
module hcube_router_bench;
    localparam int DIM = 3;
    localparam int PW = 32;
    localparam int FW = DIM + PW;
    localparam int NODES = 1 << DIM;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              inj_v [NODES];
    logic              inj_r [NODES];
    logic [FW-1:0]     inj_f [NODES];
    logic              ej_v  [NODES];
    logic              ej_r  [NODES];
    logic [FW-1:0]     ej_f  [NODES];
    logic [DIM-1:0]    li_v  [NODES];
    logic [DIM-1:0]    li_r  [NODES];
    logic [DIM*FW-1:0] li_f  [NODES];
    logic [DIM-1:0]    lo_v  [NODES];
    logic [DIM-1:0]    lo_r  [NODES];
    logic [DIM*FW-1:0] lo_f  [NODES];

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    for (genvar n = 0; n < NODES; n++) begin : g_node
        for (genvar d = 0; d < DIM; d++) begin : g_wire
            localparam int M = n ^ (1 << d);
            assign li_v[n][d] = lo_v[M][d];
            assign li_f[n][d*FW +: FW] = lo_f[M][d*FW +: FW];
            assign lo_r[n][d] = li_r[M][d];
        end
        if (n == 0) begin : g_dut
            hcube_router #(.DIM(DIM), .PAYLOAD_W(PW), .NODE_ADDR(DIM'(n))) u_hcube_router (
                .clk(clk), .rst_n(rst_n),
                .inj_valid(inj_v[n]), .inj_ready(inj_r[n]), .inj_flit(inj_f[n]),
                .ej_valid(ej_v[n]), .ej_ready(ej_r[n]), .ej_flit(ej_f[n]),
                .lk_in_valid(li_v[n]), .lk_in_ready(li_r[n]), .lk_in_flit(li_f[n]),
                .lk_out_valid(lo_v[n]), .lk_out_ready(lo_r[n]), .lk_out_flit(lo_f[n]));
        end else begin : g_peer
            hcube_router #(.DIM(DIM), .PAYLOAD_W(PW), .NODE_ADDR(DIM'(n))) u_node (
                .clk(clk), .rst_n(rst_n),
                .inj_valid(inj_v[n]), .inj_ready(inj_r[n]), .inj_flit(inj_f[n]),
                .ej_valid(ej_v[n]), .ej_ready(ej_r[n]), .ej_flit(ej_f[n]),
                .lk_in_valid(li_v[n]), .lk_in_ready(li_r[n]), .lk_in_flit(li_f[n]),
                .lk_out_valid(lo_v[n]), .lk_out_ready(lo_r[n]), .lk_out_flit(lo_f[n]));
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int hamming(input int a, input int b);
        int c = 0;
        for (int k = 0; k < DIM; k++) c += ((a ^ b) >> k) & 1;
        return c;
    endfunction

    function automatic int low_bit(input int x);
        for (int k = 0; k < DIM; k++) if ((x >> k) & 1) return k;
        return DIM;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_pair(input int src, input int dst);
        logic [PW-1:0] pay;
        int lat;
        int others;
        int h;
        pay = PW'(32'hC0DE_0000 + src * 16 + dst);
        h = hamming(src, dst);
        @(negedge clk);
        inj_v[src] = 1'b1;
        inj_f[src] = {DIM'(dst), pay};
        #1;
        chk(inj_r[src] == 1'b1, "R5 inject ready", longint'(inj_r[src]), 1);
        @(posedge clk);
        @(negedge clk);
        inj_v[src] = 1'b0;
        if (src != dst) begin
            // R2: first hop on lowest differing dimension, R4: one register stage
            chk(lo_v[src][low_bit(src ^ dst)] == 1'b1, "R2 R4 first hop link",
                longint'(lo_v[src]), longint'(1 << low_bit(src ^ dst)));
        end
        lat = 0;
        while (!ej_v[dst] && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == h, "R3 hop latency", lat, h);
        chk(ej_f[dst] == {DIM'(dst), pay}, "R1 payload", longint'(ej_f[dst]), longint'({DIM'(dst), pay}));
        others = 0;
        for (int n = 0; n < NODES; n++) if (n != dst && ej_v[n]) others++;
        chk(others == 0, "R3 single eject", others, 0);
        @(negedge clk);
    endtask

    initial begin
        logic [PW-1:0] got [3];
        int ng;
        for (int n = 0; n < NODES; n++) begin
            inj_v[n] = 1'b0;
            inj_f[n] = '0;
            ej_r[n]  = 1'b1;
        end
        do_reset();
        #1;
        for (int n = 0; n < NODES; n++) begin
            chk(ej_v[n] == 1'b0, "R7 eject idle", longint'(ej_v[n]), 0);
            chk(lo_v[n] == '0, "R7 links idle", longint'(lo_v[n]), 0);
        end

        // R6: move node 0 eject pointer past port 1, then contend
        send_pair(2, 0);
        ej_r[0] = 1'b0;
        @(negedge clk);
        inj_v[1] = 1'b1; inj_f[1] = {DIM'(0), PW'(32'hA1)};
        inj_v[2] = 1'b1; inj_f[2] = {DIM'(0), PW'(32'hA2)};
        inj_v[4] = 1'b1; inj_f[4] = {DIM'(0), PW'(32'hA4)};
        @(posedge clk);
        @(negedge clk);
        inj_v[1] = 1'b0; inj_v[2] = 1'b0; inj_v[4] = 1'b0;
        @(negedge clk);
        chk(ej_v[0] == 1'b1, "R6 first winner valid", longint'(ej_v[0]), 1);
        chk(ej_f[0][PW-1:0] == PW'(32'hA4), "R6 first winner", longint'(ej_f[0][PW-1:0]), 32'hA4);
        chk(lo_v[1][0] == 1'b1, "R8 loser held dim0", longint'(lo_v[1][0]), 1);
        chk(lo_v[2][1] == 1'b1, "R8 loser held dim1", longint'(lo_v[2][1]), 1);
        repeat (3) @(negedge clk);
        chk(ej_v[0] == 1'b1 && ej_f[0][PW-1:0] == PW'(32'hA4), "R5 stalled hold",
            longint'(ej_f[0][PW-1:0]), 32'hA4);
        ej_r[0] = 1'b1;
        ng = 0;
        for (int c = 0; c < 20; c++) begin
            if (ej_v[0] && ng < 3) begin
                got[ng] = ej_f[0][PW-1:0];
                ng++;
            end
            @(negedge clk);
        end
        chk(ng == 3, "R8 all delivered", ng, 3);
        chk(got[0] == PW'(32'hA4), "R6 order 0", longint'(got[0]), 32'hA4);
        chk(got[1] == PW'(32'hA1), "R6 order 1", longint'(got[1]), 32'hA1);
        chk(got[2] == PW'(32'hA2), "R6 order 2", longint'(got[2]), 32'hA2);

        // R1 R2 R3 R4: every source/destination pair
        for (int s = 0; s < NODES; s++) begin
            for (int t = 0; t < NODES; t++) begin
                send_pair(s, t);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule